// File: doc/BRIEF.md
# RGBW Lamp Color Generator

This block turns a set of lamp settings into four 8-bit duty values for the red, green, blue and white channels of a lamp driver. The settings arrive as parallel, synchronous words from a serial front end. They are a mode flag, a dimming shift, a white-saturation level, a hue index and four raw channel bytes. A load strobe captures one complete setting. The outputs then hold until the next strobe.

In direct mode the four raw bytes reach the outputs unchanged. In generated mode the raw bytes play no part. A base color comes from a six-segment hue wheel addressed by the index, and white is mixed in by the saturation level. Every channel is then dimmed by a right shift instead of a divider. The four duty values feed a separate PWM stage.

Top module: `rgbw_color_gen`

## Requirements
- R1: A synchronous active-high `rst` drives all four duty outputs to zero at the next rising edge. It takes priority over `load`.
- R2: With `load` high at a rising edge, the outputs take the value computed from the inputs present at that edge. Before that edge they keep their previous value.
- R3: With `load` low (and `rst` low), all four outputs hold their values whatever the other inputs do.
- R4: With `direct_mode` = 1 at a load, `duty_r`, `duty_g`, `duty_b` and `duty_w` equal `raw_r`, `raw_g`, `raw_b` and `raw_w`. Shift, saturation and hue have no effect.
- R5: With `direct_mode` = 0 at a load, the raw bytes have no effect on any output.
- R6: Hue wheel. Let p = `hue_idx`*6, segment s = p/256 and ramp f = p mod 256. The base (R,G,B) is (255,f,0) for s=0, (255-f,255,0) for s=1, (0,255,f) for s=2, (0,255-f,255) for s=3, (f,0,255) for s=4 and (255,0,255-f) for s=5.
- R7: In generated mode each base channel c becomes c - floor(c*`white_sat`/256) before dimming.
- R8: In generated mode every mixed RGB channel is shifted right by `dim_shift` (0 is full brightness, 7 the dimmest), and `duty_w` equals `white_sat` shifted right by `dim_shift`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture strobe for all settings |
| direct_mode | input | 1 | 1: raw pass-through, 0: generated color |
| dim_shift | input | 3 | Right-shift amount for dimming |
| white_sat | input | 8 | White-saturation level |
| hue_idx | input | 8 | Position on the hue wheel |
| raw_r | input | 8 | Raw red byte |
| raw_g | input | 8 | Raw green byte |
| raw_b | input | 8 | Raw blue byte |
| raw_w | input | 8 | Raw white byte |
| duty_r | output | 8 | Red duty value |
| duty_g | output | 8 | Green duty value |
| duty_b | output | 8 | Blue duty value |
| duty_w | output | 8 | White duty value |

## Verification
The assertions check on every cycle that reset clears the outputs, that the outputs hold between strobes, that direct mode copies the raw bytes, that the white output is the shifted saturation, and that no dimmed RGB channel exceeds full scale shifted by the same amount. The exact hue-wheel values at segment edges and inside ramps can only be shown by the bench's scenarios. The same holds for the rounding of the white mix, for the claim that raw bytes leave generated output untouched, and for the one-edge timing of a load.

// File: rtl/rgbw_color_gen.sv
module rgbw_color_gen #(
  parameter int W   = 8,
  parameter int SHW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           direct_mode,
  input  logic [SHW-1:0] dim_shift,
  input  logic [W-1:0]   white_sat,
  input  logic [W-1:0]   hue_idx,
  input  logic [W-1:0]   raw_r,
  input  logic [W-1:0]   raw_g,
  input  logic [W-1:0]   raw_b,
  input  logic [W-1:0]   raw_w,
  output logic [W-1:0]   duty_r,
  output logic [W-1:0]   duty_g,
  output logic [W-1:0]   duty_b,
  output logic [W-1:0]   duty_w
);
  localparam int PW = W + 3;
  localparam logic [W-1:0] FULL = '1;

  logic [PW-1:0] pos;
  logic [2:0]    seg;
  logic [W-1:0]  up, dn;
  logic [W-1:0]  base [3];
  logic [W-1:0]  dimmed [3];
  logic [W-1:0]  white_dim;

  assign pos = PW'(hue_idx) * PW'(6);
  assign seg = pos[PW-1:W];
  assign up  = pos[W-1:0];
  assign dn  = FULL - up;

  always_comb begin
    base[0] = '0;
    base[1] = '0;
    base[2] = '0;
    case (seg)
      3'd0:    begin base[0] = FULL; base[1] = up;   base[2] = '0;   end
      3'd1:    begin base[0] = dn;   base[1] = FULL; base[2] = '0;   end
      3'd2:    begin base[0] = '0;   base[1] = FULL; base[2] = up;   end
      3'd3:    begin base[0] = '0;   base[1] = dn;   base[2] = FULL; end
      3'd4:    begin base[0] = up;   base[1] = '0;   base[2] = FULL; end
      default: begin base[0] = FULL; base[1] = '0;   base[2] = dn;   end
    endcase
  end

  for (genvar i = 0; i < 3; i++) begin : g_ch
    logic [2*W-1:0] prod;
    logic [W-1:0]   mixed;
    assign prod      = (2*W)'(base[i]) * (2*W)'(white_sat);
    assign mixed     = base[i] - prod[2*W-1:W];
    assign dimmed[i] = mixed >> dim_shift;
  end

  assign white_dim = white_sat >> dim_shift;

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_r <= '0;
      duty_g <= '0;
      duty_b <= '0;
      duty_w <= '0;
    end else if (load) begin
      if (direct_mode) begin
        duty_r <= raw_r;
        duty_g <= raw_g;
        duty_b <= raw_b;
        duty_w <= raw_w;
      end else begin
        duty_r <= dimmed[0];
        duty_g <= dimmed[1];
        duty_b <= dimmed[2];
        duty_w <= white_dim;
      end
    end
  end
endmodule

// File: rtl/rgbw_color_gen_chk.sv
module rgbw_color_gen_chk #(
  parameter int W   = 8,
  parameter int SHW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           load,
  input logic           direct_mode,
  input logic [SHW-1:0] dim_shift,
  input logic [W-1:0]   white_sat,
  input logic [W-1:0]   raw_r,
  input logic [W-1:0]   raw_g,
  input logic [W-1:0]   raw_b,
  input logic [W-1:0]   raw_w,
  input logic [W-1:0]   duty_r,
  input logic [W-1:0]   duty_g,
  input logic [W-1:0]   duty_b,
  input logic [W-1:0]   duty_w
);
  localparam logic [W-1:0] FULL = '1;
  logic rst_q = 1'b0;

  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk) begin
    if (rst_q) begin
      a_r1_reset_clears: assert ({duty_r, duty_g, duty_b, duty_w} == '0)
        else $error("reset did not clear outputs");
    end
  end

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(duty_r) && $stable(duty_g) && $stable(duty_b) && $stable(duty_w)));

  a_r4_direct_copy: assert property (@(posedge clk) disable iff (rst)
    (load && direct_mode) |=> (duty_r == $past(raw_r) && duty_g == $past(raw_g) &&
                               duty_b == $past(raw_b) && duty_w == $past(raw_w)));

  a_r8_white_level: assert property (@(posedge clk) disable iff (rst)
    (load && !direct_mode) |=> duty_w == ($past(white_sat) >> $past(dim_shift)));

  a_r8_dim_bound: assert property (@(posedge clk) disable iff (rst)
    (load && !direct_mode) |=> (duty_r <= (FULL >> $past(dim_shift)) &&
                                duty_g <= (FULL >> $past(dim_shift)) &&
                                duty_b <= (FULL >> $past(dim_shift))));
endmodule

bind rgbw_color_gen rgbw_color_gen_chk #(.W(W), .SHW(SHW)) u_chk (
  .clk(clk), .rst(rst), .load(load), .direct_mode(direct_mode),
  .dim_shift(dim_shift), .white_sat(white_sat),
  .raw_r(raw_r), .raw_g(raw_g), .raw_b(raw_b), .raw_w(raw_w),
  .duty_r(duty_r), .duty_g(duty_g), .duty_b(duty_b), .duty_w(duty_w)
);

// File: tb/sim_rgbw_color_gen.sv
module sim_rgbw_color_gen;
  localparam int PERIOD = 10;
  localparam int NV = 13;
  // {direct, shift, sat, hue, raw{r,g,b,w}, expected{r,g,b,w}}
  localparam logic [83:0] VEC [NV] = '{
    {1'b1, 3'd5, 8'd77,  8'd99,  32'h12345678, 32'h12345678},
    {1'b0, 3'd0, 8'd0,   8'd0,   32'hAABBCCDD, 32'hFF000000},
    {1'b0, 3'd0, 8'd0,   8'd128, 32'h11111111, 32'h00FFFF00},
    {1'b0, 3'd0, 8'd0,   8'd43,  32'h00000000, 32'hFDFF0000},
    {1'b0, 3'd0, 8'd0,   8'd255, 32'hFFFFFFFF, 32'hFF000500},
    {1'b0, 3'd0, 8'd128, 8'd0,   32'h01020304, 32'h80000080},
    {1'b0, 3'd0, 8'd255, 8'd0,   32'h00000000, 32'h010000FF},
    {1'b0, 3'd7, 8'd0,   8'd0,   32'h55555555, 32'h01000000},
    {1'b0, 3'd3, 8'd200, 8'd0,   32'h00000000, 32'h07000019},
    {1'b0, 3'd1, 8'd64,  8'd100, 32'hDEADBEEF, 32'h00602120},
    {1'b0, 3'd2, 8'd0,   8'd200, 32'h00000000, 32'h2C003F00},
    {1'b1, 3'd7, 8'd255, 8'd0,   32'hFFFFFFFF, 32'hFFFFFFFF},
    {1'b0, 3'd0, 8'd0,   8'd170, 32'hA5A5A5A5, 32'h0003FF00}
  };

  logic clk = 1'b0;
  logic rst, load, direct_mode;
  logic [2:0] dim_shift;
  logic [7:0] white_sat, hue_idx, raw_r, raw_g, raw_b, raw_w;
  logic [7:0] duty_r, duty_g, duty_b, duty_w;
  int checks = 0;
  int fails = 0;

  always #(PERIOD/2) clk = ~clk;

  rgbw_color_gen u0 (
    .clk(clk), .rst(rst), .load(load), .direct_mode(direct_mode),
    .dim_shift(dim_shift), .white_sat(white_sat), .hue_idx(hue_idx),
    .raw_r(raw_r), .raw_g(raw_g), .raw_b(raw_b), .raw_w(raw_w),
    .duty_r(duty_r), .duty_g(duty_g), .duty_b(duty_b), .duty_w(duty_w)
  );

  function automatic logic [31:0] outs();
    return {duty_r, duty_g, duty_b, duty_w};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [51:0] s, input logic ld);
    {direct_mode, dim_shift, white_sat, hue_idx, raw_r, raw_g, raw_b, raw_w} = s;
    load = ld;
  endtask

  task automatic apply(input logic [51:0] s);
    @(negedge clk);
    drive(s, 1'b1);
    @(negedge clk);
    load = 1'b0;
  endtask

  initial begin
    rst = 1'b1;
    drive(52'h0, 1'b0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset state", outs(), 32'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = VEC[i][83] ? "R4 direct" : "R6/R7/R8 generated";
      apply(VEC[i][83:32]);
      check(tag, outs(), VEC[i][31:0]);
    end

    // R2: value held until the loading edge, updated right after it
    apply({1'b1, 3'd0, 8'd0, 8'd0, 32'h0A0B0C0D});
    @(negedge clk);
    drive({1'b1, 3'd0, 8'd0, 8'd0, 32'h99887766}, 1'b1);
    #1 check("R2 before edge", outs(), 32'h0A0B0C0D);
    @(negedge clk);
    load = 1'b0;
    check("R2 after edge", outs(), 32'h99887766);

    // R3: inputs change without load
    drive({1'b0, 3'd4, 8'd33, 8'd77, 32'h01010101}, 1'b0);
    repeat (3) @(negedge clk);
    check("R3 hold without load", outs(), 32'h99887766);

    // R5: generated output independent of raw bytes
    apply({1'b0, 3'd0, 8'd0, 8'd128, 32'h00000000});
    check("R5 raw zero", outs(), 32'h00FFFF00);
    apply({1'b0, 3'd0, 8'd0, 8'd128, 32'hFFFFFFFF});
    check("R5 raw ones", outs(), 32'h00FFFF00);

    // R8: shift extremes on the same color
    apply({1'b0, 3'd7, 8'd255, 8'd0, 32'h0});
    check("R8 dimmest", outs(), 32'h00000001);

    // R1: reset wins over a simultaneous load
    @(negedge clk);
    drive({1'b1, 3'd0, 8'd0, 8'd0, 32'h55667788}, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    load = 1'b0;
    check("R1 reset over load", outs(), 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule